// File: doc/BRIEF.md
# Buck Converter Start-up and Fault Sequencer

This block is the digital supervisor of a voltage-mode synchronous buck controller. Its inputs are raw comparator flags: supply good, compensation-pin pull-down, feedback under-voltage, feedback above the 125% and 105% levels, low-side over-current, over-temperature trip and over-temperature release. Each flag passes through a two-flop synchronizer. The block decides when the power stage may switch, when the low-side switch must be held on, and when both gates must stay low.

On each clean start the sequencer runs a current-limit measurement phase and stores the sampled trip code. It then ramps a digital reference code from zero to full scale, one step per time-base tick, and enters regulation. Under-voltage and over-current faults cause a hiccup: the drivers stay off for a fixed number of ticks, and then the ramp starts again. An over-voltage fault clamps the output through the low side, then shuts the drivers off and latches. The latch is cleared only by a compensation-pin pull-down or by loss of supply. Over-temperature holds the stage off until a separate release flag arrives.

Top module: `buck_fault_seq`

## Requirements
- R1: Reset, and a low supply-good flag in any state, give drv_off=1, pwm_en=0, ls_force=0 and ss_ref=0. Once the flag reaches the core, the outputs respond on the next clock edge.
- R2: Each start first spends OCS_TICKS ticks in a measurement phase with all drivers off. At the end of that phase ocs_code_i is captured on ocs_trip_code, and the value is held unchanged until the next measurement phase.
- R3: During soft-start pwm_en=1 and ss_ref starts at 0. ss_ref rises by exactly one on each tick until it reaches all ones, and it then stays there in regulation.
- R4: An under-voltage or 125% over-voltage flag acts only after its synchronized level has stayed high for DEB_CYCLES consecutive clocks. A shorter pulse has no effect on the outputs.
- R5: A debounced under-voltage, or any synchronized over-current, during soft-start or regulation turns the drivers off (drv_off=1, ss_ref=0) for HICCUP_TICKS ticks. Soft-start then begins again from ss_ref=0.
- R6: A debounced 125% over-voltage gives ls_force=1 with pwm_en=0. The clamp is held until the 105% flag falls, and then all drivers turn off.
- R7: After an over-voltage shutdown the drivers stay off, whatever the other inputs do, until the compensation-pin disable is asserted or supply-good falls.
- R8: An over-temperature trip holds all drivers off. Only the release flag ends the hold, and a new measurement phase then follows.
- R9: While comp_dis_a is high the drivers are off. When it falls, a fresh measurement phase and soft-start follow.
- R10: Priority from high to low: supply-low, disable, over-temperature, over-voltage latch or clamp, over-current, under-voltage. Examples: an over-current during the clamp does not end the clamp, and a temperature release does not end an over-voltage latch.
- R11: In every cycle exactly one of pwm_en, ls_force and drv_off is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe |
| por_ok_a | input | 1 | Supply above power-on threshold (async) |
| comp_dis_a | input | 1 | Compensation pin pulled below disable level (async) |
| fb_uv_a | input | 1 | Feedback below 50% of reference (async) |
| fb_ov_hi_a | input | 1 | Feedback above 125% (async) |
| fb_ov_lo_a | input | 1 | Feedback above 105% (async) |
| ls_oc_a | input | 1 | Low-side over-current (async) |
| ot_trip_a | input | 1 | Junction over-temperature trip (async) |
| ot_clear_a | input | 1 | Temperature has cooled enough to release (async) |
| ocs_code_i | input | CODE_W | Sampled current-limit code |
| ss_ref | output | REF_W | Soft-start reference code |
| pwm_en | output | 1 | Allow PWM switching |
| ls_force | output | 1 | Hold low side on, high side off |
| drv_off | output | 1 | Both gates low |
| ocs_trip_code | output | CODE_W | Latched current-limit code |

## Verification
The stimulus covers a clean start to full scale; an under-voltage pulse one clock shorter than the debounce window followed by a held one, which separates the debounce from the hiccup path; and a single-cycle over-current pulse, which shows that this fault is not filtered. The over-voltage path is driven with an over-current during the clamp and a temperature trip-and-release during the latch, so any wrong priority or a latch clearing too early becomes visible. Disable and supply-low tests, including the two together, show which restart sources begin a fresh measurement phase.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [2:0] {
    ST_OFF, ST_OCS, ST_SOFT, ST_RUN, ST_HIC, ST_CLAMP, ST_LATCH, ST_OTH
  } bfs_state_e;

  // Saturating increment shared by the debounce counters
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/bfs_sync.sv
module bfs_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bfs_debounce.sv
module bfs_debounce #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_s,
  output logic hit
);
  import bfs_pkg::*;
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (in_s) cnt <= CW'(sat_inc(32'(cnt), CYC));
    else           cnt <= '0;
  end

  assign hit = (cnt == CW'(CYC));

  // R4: a qualified level implies the level was present on the previous clock
  a_r4_hit_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(in_s));
endmodule

// File: rtl/buck_fault_seq.sv
module buck_fault_seq #(
  parameter int REF_W        = 8,
  parameter int CODE_W       = 6,
  parameter int DEB_CYCLES   = 20,
  parameter int OCS_TICKS    = 94,
  parameter int HICCUP_TICKS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              por_ok_a,
  input  logic              comp_dis_a,
  input  logic              fb_uv_a,
  input  logic              fb_ov_hi_a,
  input  logic              fb_ov_lo_a,
  input  logic              ls_oc_a,
  input  logic              ot_trip_a,
  input  logic              ot_clear_a,
  input  logic [CODE_W-1:0] ocs_code_i,
  output logic [REF_W-1:0]  ss_ref,
  output logic              pwm_en,
  output logic              ls_force,
  output logic              drv_off,
  output logic [CODE_W-1:0] ocs_trip_code
);
  import bfs_pkg::*;

  localparam int NFLAG = 8;
  localparam int TMAX  = (OCS_TICKS > HICCUP_TICKS) ? OCS_TICKS : HICCUP_TICKS;
  localparam int TW    = $clog2(TMAX + 1);
  localparam logic [REF_W-1:0] FULL = {REF_W{1'b1}};

  // synchronized flags
  logic [NFLAG-1:0] flag_s;
  bfs_sync #(.W(NFLAG)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ot_clear_a, ot_trip_a, ls_oc_a, fb_ov_lo_a, fb_ov_hi_a, fb_uv_a, comp_dis_a, por_ok_a}),
    .q(flag_s)
  );

  logic por_s, dis_s, uv_s, ovh_s, ovl_s, oc_s, ot_trip_s, ot_clr_s;
  assign {ot_clr_s, ot_trip_s, oc_s, ovl_s, ovh_s, uv_s, dis_s, por_s} = flag_s;

  // debounced comparators: index 0 under-voltage, 1 over-voltage high
  logic [1:0] deb_in, deb_hit;
  assign deb_in = {ovh_s, uv_s};

  for (genvar g = 0; g < 2; g++) begin : g_deb
    bfs_debounce #(.CYC(DEB_CYCLES)) u_deb (
      .clk(clk), .rst_n(rst_n), .in_s(deb_in[g]), .hit(deb_hit[g])
    );
  end

  logic uv_hit, ov_hit;
  assign uv_hit = deb_hit[0];
  assign ov_hit = deb_hit[1];

  bfs_state_e      st;
  logic [TW-1:0]   tcnt;
  logic            ot_act, ov_lat;

  // named internal events
  logic ot_flag, ev_ocs_done, ev_hic_done, ev_ramp_top, ev_ov_release;
  assign ot_flag       = ot_trip_s | (ot_act & ~ot_clr_s);
  assign ev_ocs_done   = (st == ST_OCS) && tick && (tcnt == TW'(OCS_TICKS - 1));
  assign ev_hic_done   = (st == ST_HIC) && tick && (tcnt == TW'(HICCUP_TICKS - 1));
  assign ev_ramp_top   = (st == ST_SOFT) && (ss_ref == FULL);
  assign ev_ov_release = (st == ST_CLAMP) && !ovl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_OFF;
      tcnt          <= '0;
      ss_ref        <= '0;
      ot_act        <= 1'b0;
      ov_lat        <= 1'b0;
      ocs_trip_code <= '0;
    end else begin
      ot_act <= ot_flag;
      if (!por_s || dis_s) begin
        st     <= ST_OFF;
        ss_ref <= '0;
        tcnt   <= '0;
        ov_lat <= 1'b0;
      end else if (ot_flag) begin
        st     <= ST_OTH;
        ss_ref <= '0;
        tcnt   <= '0;
      end else if (ov_lat) begin
        st <= ST_LATCH;
      end else begin
        case (st)
          ST_OFF, ST_OTH: begin
            st     <= ST_OCS;
            tcnt   <= '0;
            ss_ref <= '0;
          end
          ST_OCS: begin
            if (ev_ocs_done) begin
              ocs_trip_code <= ocs_code_i;
              st            <= ST_SOFT;
              tcnt          <= '0;
            end else if (tick) begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_SOFT, ST_RUN: begin
            if (ov_hit) begin
              st <= ST_CLAMP;
            end else if (oc_s || uv_hit) begin
              st     <= ST_HIC;
              tcnt   <= '0;
              ss_ref <= '0;
            end else if (ev_ramp_top) begin
              st <= ST_RUN;
            end else if (st == ST_SOFT && tick) begin
              ss_ref <= ss_ref + 1'b1;
            end
          end
          ST_HIC: begin
            if (ev_hic_done) begin
              st   <= ST_SOFT;
              tcnt <= '0;
            end else if (tick) begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_CLAMP: begin
            if (ev_ov_release) begin
              st     <= ST_LATCH;
              ov_lat <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pwm_en   = (st == ST_SOFT) || (st == ST_RUN);
  assign ls_force = (st == ST_CLAMP);
  assign drv_off  = !pwm_en && !ls_force;

  // R1: supply loss seen by the core shuts the stage on the next edge
  a_r1_por_off: assert property (@(posedge clk) disable iff (!rst_n)
    !por_s |=> (drv_off && ss_ref == '0));
  // R2: trip code never moves while switching continues
  a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && $past(pwm_en)) |-> $stable(ocs_trip_code));
  // R3: the reference moves by at most one step while switching
  a_r3_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && $past(pwm_en)) |-> (ss_ref == $past(ss_ref) || ss_ref == $past(ss_ref) + 1'b1));
  // R6: a clamp begins only after a qualified over-voltage
  a_r6_clamp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_force) |-> $past(ov_hit));
  // R7: the over-voltage latch keeps both gates low
  a_r7_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ov_lat |-> drv_off);
  // R8: an active thermal condition turns the stage off on the next edge
  a_r8_ot_off: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |=> drv_off);
  // R11: exactly one drive mode
  a_r11_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pwm_en, ls_force, drv_off}) == 1);
endmodule

// File: tb/buck_fault_seq_tb.sv
module buck_fault_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REF_W = 4, CODE_W = 6, DEB = 3, OCS = 4, HIC = 6;
  localparam int FULL = (1 << REF_W) - 1;
  // flag bit order: 0 supply, 1 disable, 2 uv, 3 ov125, 4 ov105, 5 oc, 6 ot trip, 7 ot release
  localparam int M_OFF = 0, M_OCS = 1, M_SOFT = 2, M_RUN = 3, M_HIC = 4, M_CLAMP = 5, M_LAT = 6, M_OTH = 7;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [7:0] flags = '0;
  logic [CODE_W-1:0] ocs_code_i = '0;
  logic [REF_W-1:0] ss_ref;
  logic pwm_en, ls_force, drv_off;
  logic [CODE_W-1:0] ocs_trip_code;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_fault_seq #(.REF_W(REF_W), .CODE_W(CODE_W), .DEB_CYCLES(DEB),
                   .OCS_TICKS(OCS), .HICCUP_TICKS(HIC)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .por_ok_a(flags[0]), .comp_dis_a(flags[1]), .fb_uv_a(flags[2]),
    .fb_ov_hi_a(flags[3]), .fb_ov_lo_a(flags[4]), .ls_oc_a(flags[5]),
    .ot_trip_a(flags[6]), .ot_clear_a(flags[7]), .ocs_code_i(ocs_code_i),
    .ss_ref(ss_ref), .pwm_en(pwm_en), .ls_force(ls_force), .drv_off(drv_off),
    .ocs_trip_code(ocs_trip_code)
  );

  // behavioural reference model
  logic [7:0] m_p1 = '0, m_p2 = '0;
  int m_uv = 0, m_ov = 0, m_st = M_OFF, m_t = 0, m_ss = 0, m_code = 0;
  bit m_ota = 0, m_lat = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = '0; m_p2 = '0; m_uv = 0; m_ov = 0; m_st = M_OFF;
      m_t = 0; m_ss = 0; m_code = 0; m_ota = 0; m_lat = 0;
    end else begin
      bit otf, newlat;
      otf = m_p2[6] || (m_ota && !m_p2[7]);
      newlat = m_lat;
      if (!m_p2[0] || m_p2[1]) begin m_st = M_OFF; m_ss = 0; m_t = 0; newlat = 0; end
      else if (otf) begin m_st = M_OTH; m_ss = 0; m_t = 0; end
      else if (m_lat) m_st = M_LAT;
      else if (m_st == M_OFF || m_st == M_OTH) begin m_st = M_OCS; m_t = 0; m_ss = 0; end
      else if (m_st == M_OCS) begin
        if (tick) begin
          if (m_t == OCS - 1) begin m_code = int'(ocs_code_i); m_st = M_SOFT; m_t = 0; end
          else m_t++;
        end
      end else if (m_st == M_SOFT || m_st == M_RUN) begin
        if (m_ov == DEB) m_st = M_CLAMP;
        else if (m_p2[5] || m_uv == DEB) begin m_st = M_HIC; m_t = 0; m_ss = 0; end
        else if (m_st == M_SOFT) begin
          if (m_ss == FULL) m_st = M_RUN;
          else if (tick) m_ss++;
        end
      end else if (m_st == M_HIC) begin
        if (tick) begin
          if (m_t == HIC - 1) begin m_st = M_SOFT; m_t = 0; end
          else m_t++;
        end
      end else if (m_st == M_CLAMP) begin
        if (!m_p2[4]) begin m_st = M_LAT; newlat = 1; end
      end
      m_ota = otf; m_lat = newlat;
      m_uv = m_p2[2] ? ((m_uv >= DEB) ? DEB : m_uv + 1) : 0;
      m_ov = m_p2[3] ? ((m_ov >= DEB) ? DEB : m_ov + 1) : 0;
      m_p2 = m_p1; m_p1 = flags;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      M_OCS: return "R2";  M_SOFT, M_RUN: return "R3";  M_HIC: return "R5";
      M_CLAMP: return "R6"; M_LAT: return "R7"; M_OTH: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, sampled at the falling edge
  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 3 == 0);
    if (rst_n) begin
      int ep, el, eo;
      ep = (m_st == M_SOFT || m_st == M_RUN);
      el = (m_st == M_CLAMP);
      eo = !(ep || el);
      chk({pwm_en, ls_force, drv_off} == {ep[0], el[0], eo[0]}, tag_of(m_st),
          {pwm_en, ls_force, drv_off}, {ep[0], el[0], eo[0]});
      chk(int'(ss_ref) == m_ss, "R3", int'(ss_ref), m_ss);
      chk(int'(ocs_trip_code) == m_code, "R2", int'(ocs_trip_code), m_code);
      chk($countones({pwm_en, ls_force, drv_off}) == 1, "R11",
          $countones({pwm_en, ls_force, drv_off}), 1);
    end
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pwm(input string tag);
    int n = 0;
    while (!pwm_en && n < 400) begin @(negedge clk); n++; end
    chk(pwm_en, tag, pwm_en, 1);
  endtask

  task automatic wait_full(input string tag);
    int n = 0;
    while (int'(ss_ref) != FULL && n < 400) begin @(negedge clk); n++; end
    chk(int'(ss_ref) == FULL, tag, int'(ss_ref), FULL);
  endtask

  initial begin
    step(3);
    chk(drv_off && !pwm_en && ss_ref == 0, "R1", drv_off, 1);       // reset state
    rst_n = 1;
    ocs_code_i = 6'h2A;
    flags[0] = 1;
    step(5);
    chk(!pwm_en, "R2", pwm_en, 0);                                  // measurement phase
    wait_pwm("R3");
    chk(int'(ss_ref) <= 1, "R3", int'(ss_ref), 0);
    ocs_code_i = 6'h15;
    wait_full("R3");
    step(2);
    chk(ocs_trip_code == 6'h2A, "R2", int'(ocs_trip_code), 'h2A);

    flags[2] = 1; step(2); flags[2] = 0; step(10);                  // short uv pulse
    chk(pwm_en && int'(ss_ref) == FULL, "R4", pwm_en, 1);
    flags[2] = 1; step(6); flags[2] = 0; step(2);                   // held uv
    chk(drv_off && ss_ref == 0, "R5", drv_off, 1);
    wait_pwm("R5");
    chk(int'(ss_ref) <= 1, "R5", int'(ss_ref), 0);
    wait_full("R5");

    flags[5] = 1; step(1); flags[5] = 0; step(4);                   // one-cycle oc
    chk(drv_off, "R5", drv_off, 1);
    wait_pwm("R5");
    wait_full("R5");

    flags[3] = 1; flags[4] = 1; step(8);
    chk(ls_force && !pwm_en, "R6", ls_force, 1);
    flags[5] = 1; step(6);
    chk(ls_force, "R10", ls_force, 1);                              // oc cannot end clamp
    flags[5] = 0; flags[3] = 0; step(5);
    chk(ls_force, "R6", ls_force, 1);
    flags[4] = 0; step(5);
    chk(drv_off && !ls_force, "R6", drv_off, 1);
    step(30);
    chk(drv_off, "R7", drv_off, 1);
    flags[6] = 1; step(1); flags[6] = 0; step(5);
    flags[7] = 1; step(1); flags[7] = 0; step(40);
    chk(drv_off, "R10", drv_off, 1);                                // release does not clear latch

    flags[1] = 1; step(10);
    chk(drv_off, "R9", drv_off, 1);
    flags[1] = 0; step(4);
    chk(!pwm_en, "R9", pwm_en, 0);
    wait_pwm("R7");
    wait_full("R9");

    flags[6] = 1; step(1); flags[6] = 0; step(5);
    chk(drv_off, "R8", drv_off, 1);
    step(30);
    chk(drv_off, "R8", drv_off, 1);
    flags[7] = 1; step(1); flags[7] = 0;
    wait_pwm("R8");
    wait_full("R8");

    flags[0] = 0; step(3);
    chk(drv_off && ss_ref == 0, "R1", drv_off, 1);
    flags[1] = 1; flags[0] = 1; step(10);
    chk(drv_off, "R10", drv_off, 1);                                // disable beats supply
    flags[1] = 0;
    wait_pwm("R9");
    step(5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule